// File: doc/BRIEF.md
# Cascadable Multi-Channel Timer/Counter

This block holds a set of free-running up-counters, each a channel with its own clock selection, two compare values, a start command, an interrupt mask and a count that software can read. The counter width is fixed at elaboration as 16 or 32 bits. In waveform mode a channel drives an output that goes high when the count reaches compare A and low when it reaches compare C. A block command restarts every channel from zero in the same cycle.

A 32-bit build covers a full 32-bit time base with one channel, and the other channels go unused. A 16-bit build forms the same range from two channels. Channel 0 runs with compare A = 0 and compare C = 0x8000, so its waveform output is a square wave that rises each time the count wraps. A block routing field feeds that output to channel 1 as an external clock. Channel 1 then counts channel 0 wraps, and software reads the pair as upper then lower then upper again.

Register access uses a flat byte-addressed bus. Writes take effect on the clock edge. Reads are combinational from the address. Channel n occupies bytes n*0x20 to n*0x20+0x1F. The block registers start at NUM_CH*0x20.

Top module: `tc_block`

## Requirements
- R1: After reset every count reads 0, every waveform output is low, every interrupt mask reads 0 and every channel is stopped.
- R2: Writing a value with bit 0 set to a channel command register (offset 0x00) starts that channel. A stopped channel keeps its count.
- R3: Mode register (offset 0x04) bits [2:0] select the count clock: 0 is the block clock, 1 is clock/2, 2 is clock/8, 3 is clock/32 and 4 is the external input. After a sync, a channel running at clock/N reads floor(k/N) k edges later.
- R4: A channel free-runs through all 2^CNT_W values and wraps from all-ones to zero. Compare C never resets it. A 32-bit build passes 0xFFFF straight to 0x10000.
- R5: With mode bit 3 set, the waveform output goes high on the advance that brings the count to compare A (offset 0x0C). It goes low on the advance that brings the count to compare C (offset 0x10). If both match, the output goes low. With bit 3 clear, the output is low from the next edge on.
- R6: In a 16-bit build, writing 1 to block mode bits [1:0] (offset +0x04) routes channel 0's waveform output to channel 1's external input. Channel 1 advances exactly once per rising edge of that input, on the third clock edge after the edge where channel 0 wraps.
- R7: Writing bit 0 = 1 to the block command register (offset +0x00) clears every channel's count on that edge and restarts the clock dividers. Waveform levels and the start state are kept.
- R8: The count register (offset 0x08) returns the current count, and a write to it changes nothing.
- R9: The interrupt-disable register (offset 0x14, 8 bits) is write-one-to-set. A read returns the accumulated mask, and writing zeros clears nothing.
- R10: A chained read samples upper, then lower 4 cycles later, then upper 4 cycles after that. When both upper samples agree, {upper, lower} equals the true 32-bit count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, sampled on the clock edge |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |
| wave_o | output | NUM_CH | Waveform output of each channel |

## Verification
The embedded assertions check several rules on every clock edge. A sync clears the count on the next cycle. A stopped or untimed channel holds its count. Each advance adds exactly one, with natural wrap. A divided tick never lasts two cycles, and a detected external rise is a single-cycle pulse. The assertions also check the waveform's set-on-A rule and its forced-low rule when waveform mode is off.

Only the bench scenarios can show the rest. This covers the exact division ratios and the same-edge restart across channels. It also covers the read-only count, the write-one-to-set mask, and compare-C priority on a double match. The bench also confirms the three-edge lag of the cascaded channel across a real 16-bit wrap, and that the upper-lower-upper read yields the true count or flags the carry.

// File: rtl/tc_pkg.sv
package tc_pkg;
   // word index within a channel window (address bits [4:2])
   localparam logic [2:0] REG_CMD   = 3'd0;
   localparam logic [2:0] REG_MODE  = 3'd1;
   localparam logic [2:0] REG_CNT   = 3'd2;
   localparam logic [2:0] REG_CMPA  = 3'd3;
   localparam logic [2:0] REG_CMPC  = 3'd4;
   localparam logic [2:0] REG_IMASK = 3'd5;
   // word index within the block window
   localparam logic [2:0] BLK_CMD   = 3'd0;
   localparam logic [2:0] BLK_MODE  = 3'd1;

   localparam int CH_SPAN_LOG2 = 5;
   localparam int IMASK_W      = 8;
   localparam int MODE_W       = 4;
   localparam int MODE_WAVE    = 3;

   localparam logic [1:0] ROUTE_CH0_WAVE = 2'b01;

   typedef enum logic [2:0] {
      CLK_DIV1  = 3'd0,
      CLK_DIV2  = 3'd1,
      CLK_DIV8  = 3'd2,
      CLK_DIV32 = 3'd3,
      CLK_EXT   = 3'd4
   } clk_sel_e;

   // log2 of the division ratio for divided clock index idx
   function automatic int div_shift(input int idx);
      case (idx)
         0:       return 0;
         1:       return 1;
         2:       return 3;
         default: return 5;
      endcase
   endfunction
endpackage

// File: rtl/tc_prescaler.sv
module tc_prescaler #(
   parameter int NUM_DIV = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clear_i,
   output logic [NUM_DIV-1:0] tick_o
);
   localparam int PRE_W = tc_pkg::div_shift(NUM_DIV - 1);

   initial begin
      if (NUM_DIV < 2 || NUM_DIV > 4) $error("tc_prescaler: NUM_DIV must be 2..4");
      if (PRE_W < 1) $error("tc_prescaler: divider chain too short");
   end

   logic [PRE_W-1:0] pre_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pre_q <= '0;
      else if (clear_i) pre_q <= '0;
      else              pre_q <= pre_q + 1'b1;
   end

   for (genvar g = 0; g < NUM_DIV; g++) begin : g_tick
      localparam int SH = tc_pkg::div_shift(g);
      if (SH == 0) begin : g_full
         assign tick_o[g] = 1'b1;
      end else begin : g_div
         assign tick_o[g] = &pre_q[SH-1:0];

         // R3: a divided tick is never high on two consecutive cycles
         assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
            tick_o[g] |=> !tick_o[g])
            else $error("divided tick held two cycles");
      end
   end
endmodule

// File: rtl/tc_edge_detect.sv
module tc_edge_detect (
   input  logic clk,
   input  logic rst_n,
   input  logic flush_i,
   input  logic in_i,
   output logic rise_o
);
   logic s1_q, s2_q, s3_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_q <= 1'b0;
         s2_q <= 1'b0;
         s3_q <= 1'b0;
      end else if (flush_i) begin
         // restart: forget any edge in flight
         s1_q <= in_i;
         s2_q <= in_i;
         s3_q <= in_i;
      end else begin
         s1_q <= in_i;
         s2_q <= s1_q;
         s3_q <= s2_q;
      end
   end

   assign rise_o = s2_q & ~s3_q;

   // R6: one rising edge yields one single-cycle pulse
   assert_single_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o)
      else $error("external rise pulse longer than one cycle");
endmodule

// File: rtl/tc_channel.sv
module tc_channel #(
   parameter int CNT_W   = 16,
   parameter int NUM_DIV = 4,
   parameter int DATA_W  = 32
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       sync_i,
   input  logic                       start_i,
   input  logic                       mode_we_i,
   input  logic                       cmpa_we_i,
   input  logic                       cmpc_we_i,
   input  logic                       imask_we_i,
   input  logic [DATA_W-1:0]          wdata_i,
   input  logic [NUM_DIV-1:0]         div_tick_i,
   input  logic                       ext_i,
   output logic [CNT_W-1:0]           count_o,
   output logic [tc_pkg::MODE_W-1:0]  mode_o,
   output logic [CNT_W-1:0]           cmpa_o,
   output logic [CNT_W-1:0]           cmpc_o,
   output logic [tc_pkg::IMASK_W-1:0] imask_o,
   output logic                       wave_o
);
   import tc_pkg::*;

   initial begin
      if (CNT_W != 16 && CNT_W != 32) $error("tc_channel: CNT_W must be 16 or 32");
      if (DATA_W < CNT_W) $error("tc_channel: DATA_W narrower than counter");
   end

   logic                 running_q;
   logic [2:0]           sel_q;
   logic                 wave_en_q;
   logic [CNT_W-1:0]     cnt_q, cmpa_q, cmpc_q, nxt;
   logic [IMASK_W-1:0]   imask_q;
   logic                 out_q;
   logic                 ext_rise, tick_sel, adv;
   logic                 unused_wdata;

   assign unused_wdata = &{1'b0, wdata_i};

   tc_edge_detect i_ext_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush_i (sync_i),
      .in_i    (ext_i),
      .rise_o  (ext_rise)
   );

   always_comb begin
      tick_sel = 1'b0;
      for (int i = 0; i < NUM_DIV; i++) begin
         if (sel_q == 3'(i)) tick_sel = div_tick_i[i];
      end
      if (sel_q == CLK_EXT) tick_sel = ext_rise;
   end

   assign adv = running_q & tick_sel;
   assign nxt = cnt_q + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running_q <= 1'b0;
         sel_q     <= CLK_DIV1;
         wave_en_q <= 1'b0;
         cmpa_q    <= '0;
         cmpc_q    <= '0;
         imask_q   <= '0;
      end else begin
         if (start_i)    running_q <= 1'b1;
         if (mode_we_i) begin
            sel_q     <= wdata_i[2:0];
            wave_en_q <= wdata_i[MODE_WAVE];
         end
         if (cmpa_we_i)  cmpa_q  <= wdata_i[CNT_W-1:0];
         if (cmpc_we_i)  cmpc_q  <= wdata_i[CNT_W-1:0];
         if (imask_we_i) imask_q <= imask_q | wdata_i[IMASK_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (sync_i) cnt_q <= '0;
      else if (adv)    cnt_q <= nxt;
   end

   // waveform follows the value the counter advances to; compare C wins
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 out_q <= 1'b0;
      else if (!wave_en_q)        out_q <= 1'b0;
      else if (!sync_i && adv) begin
         if (nxt == cmpc_q)       out_q <= 1'b0;
         else if (nxt == cmpa_q)  out_q <= 1'b1;
      end
   end

   assign count_o = cnt_q;
   assign mode_o  = {wave_en_q, sel_q};
   assign cmpa_o  = cmpa_q;
   assign cmpc_o  = cmpc_q;
   assign imask_o = imask_q;
   assign wave_o  = out_q;

   assert_sync_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      sync_i |=> (count_o == '0))
      else $error("sync did not clear the count");

   assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!sync_i && !adv) |=> $stable(count_o))
      else $error("count moved without an advance");

   assert_step_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!sync_i && adv) |=> (count_o == CNT_W'($past(count_o) + 1'b1)))
      else $error("count did not step by one");

   assert_wave_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !wave_en_q |=> !wave_o)
      else $error("waveform high outside waveform mode");

   assert_wave_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wave_en_q && !sync_i && adv && (nxt == cmpa_q) && (nxt != cmpc_q)) |=> wave_o)
      else $error("waveform not set on compare A");
endmodule

// File: rtl/tc_block.sv
module tc_block #(
   parameter int CNT_W  = 16,
   parameter int NUM_CH = 2,
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [NUM_CH-1:0] wave_o
);
   import tc_pkg::*;

   localparam int NUM_DIV  = 4;
   localparam int CH_IDX_W = ADDR_W - CH_SPAN_LOG2;

   initial begin
      if (CNT_W != 16 && CNT_W != 32) $error("tc_block: CNT_W must be 16 or 32");
      if (NUM_CH < 2) $error("tc_block: at least two channels required");
      if (CH_IDX_W < 1 || (NUM_CH + 1) > (1 << CH_IDX_W)) $error("tc_block: ADDR_W too small");
      if (DATA_W < CNT_W || DATA_W < IMASK_W) $error("tc_block: DATA_W too small");
   end

   logic [CH_IDX_W-1:0]  ch_field;
   logic [2:0]           word;
   logic                 blk_sel, sync_now;
   logic [1:0]           bmode_q;
   logic [NUM_DIV-1:0]   div_tick;
   logic [NUM_CH-1:0]    ext_in, wave_int;
   logic [CNT_W-1:0]     cnt_arr  [NUM_CH];
   logic [CNT_W-1:0]     cmpa_arr [NUM_CH];
   logic [CNT_W-1:0]     cmpc_arr [NUM_CH];
   logic [MODE_W-1:0]    mode_arr [NUM_CH];
   logic [IMASK_W-1:0]   mask_arr [NUM_CH];
   logic                 unused_addr;

   assign unused_addr = &{1'b0, bus_addr[1:0]};
   assign ch_field    = bus_addr[ADDR_W-1:CH_SPAN_LOG2];
   assign word        = bus_addr[4:2];
   assign blk_sel     = (ch_field == CH_IDX_W'(NUM_CH));
   assign sync_now    = bus_wr && blk_sel && (word == BLK_CMD) && bus_wdata[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bmode_q <= '0;
      else if (bus_wr && blk_sel && word == BLK_MODE) bmode_q <= bus_wdata[1:0];
   end

   tc_prescaler #(.NUM_DIV(NUM_DIV)) i_prescaler (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (sync_now),
      .tick_o  (div_tick)
   );

   for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      logic hit;
      assign hit = bus_wr && (ch_field == CH_IDX_W'(g));

      if (g == 1 && CNT_W == 16) begin : g_cascade
         assign ext_in[g] = (bmode_q == ROUTE_CH0_WAVE) & wave_int[0];
      end else begin : g_no_ext
         assign ext_in[g] = 1'b0;
      end

      tc_channel #(.CNT_W(CNT_W), .NUM_DIV(NUM_DIV), .DATA_W(DATA_W)) i_channel (
         .clk        (clk),
         .rst_n      (rst_n),
         .sync_i     (sync_now),
         .start_i    (hit && word == REG_CMD && bus_wdata[0]),
         .mode_we_i  (hit && word == REG_MODE),
         .cmpa_we_i  (hit && word == REG_CMPA),
         .cmpc_we_i  (hit && word == REG_CMPC),
         .imask_we_i (hit && word == REG_IMASK),
         .wdata_i    (bus_wdata),
         .div_tick_i (div_tick),
         .ext_i      (ext_in[g]),
         .count_o    (cnt_arr[g]),
         .mode_o     (mode_arr[g]),
         .cmpa_o     (cmpa_arr[g]),
         .cmpc_o     (cmpc_arr[g]),
         .imask_o    (mask_arr[g]),
         .wave_o     (wave_int[g])
      );
   end

   assign wave_o = wave_int;

   always_comb begin
      bus_rdata = '0;
      for (int c = 0; c < NUM_CH; c++) begin
         if (ch_field == CH_IDX_W'(c)) begin
            case (word)
               REG_MODE:  bus_rdata = DATA_W'(mode_arr[c]);
               REG_CNT:   bus_rdata = DATA_W'(cnt_arr[c]);
               REG_CMPA:  bus_rdata = DATA_W'(cmpa_arr[c]);
               REG_CMPC:  bus_rdata = DATA_W'(cmpc_arr[c]);
               REG_IMASK: bus_rdata = DATA_W'(mask_arr[c]);
               default:   bus_rdata = '0;
            endcase
         end
      end
      if (blk_sel && word == BLK_MODE) bus_rdata = DATA_W'(bmode_q);
   end
endmodule

// File: tb/test_tc_block.sv
module test_tc_block;
   localparam int AW = 8;
   localparam int DW = 32;
   localparam logic [7:0] CH0 = 8'h00, CH1 = 8'h20, BLK = 8'h40;
   localparam logic [7:0] O_CMD = 8'h00, O_MODE = 8'h04, O_CNT = 8'h08,
                          O_CMPA = 8'h0C, O_CMPC = 8'h10, O_MASK = 8'h14;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic          rst_n;
   logic [AW-1:0] a_addr, b_addr;
   logic          a_wr, b_wr;
   logic [DW-1:0] a_wd, b_wd, a_rd, b_rd;
   logic [1:0]    a_wave, b_wave;

   tc_block #(.CNT_W(16), .NUM_CH(2), .ADDR_W(AW), .DATA_W(DW)) i_tc_block (
      .clk(clk), .rst_n(rst_n), .bus_addr(a_addr), .bus_wr(a_wr),
      .bus_wdata(a_wd), .bus_rdata(a_rd), .wave_o(a_wave));

   tc_block #(.CNT_W(32), .NUM_CH(2), .ADDR_W(AW), .DATA_W(DW)) i_tc_block_w32 (
      .clk(clk), .rst_n(rst_n), .bus_addr(b_addr), .bus_wr(b_wr),
      .bus_wdata(b_wd), .bus_rdata(b_rd), .wave_o(b_wave));

   int checks = 0;
   int fails  = 0;
   int k      = 0;
   bit done   = 1'b0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // tasks start and end just after a falling edge
   task automatic wr(input int which, input logic [7:0] addr, input logic [31:0] data);
      if (which == 0) begin a_addr = addr; a_wd = data; a_wr = 1'b1; end
      else            begin b_addr = addr; b_wd = data; b_wr = 1'b1; end
      @(negedge clk);
      a_wr = 1'b0; b_wr = 1'b0;
      k++;
   endtask

   task automatic sync_both();
      a_addr = BLK; a_wd = 32'h1; a_wr = 1'b1;
      b_addr = BLK; b_wd = 32'h1; b_wr = 1'b1;
      @(negedge clk);
      a_wr = 1'b0; b_wr = 1'b0;
      k = 0;
   endtask

   task automatic sync_one(input int which);
      wr(which, BLK, 32'h1);
      k = 0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
      k += n;
   endtask

   task automatic rd(input int which, input logic [7:0] addr, output logic [31:0] data);
      if (which == 0) a_addr = addr; else b_addr = addr;
      #1;
      data = (which == 0) ? a_rd : b_rd;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      rd(0, CH0 + O_CNT, v);  chk("R1 count after reset", v, 0);
      rd(0, CH0 + O_MASK, v); chk("R1 mask after reset", v, 0);
      chk("R1 wave after reset", {30'd0, a_wave | b_wave}, 0);
      idle(10);
      rd(1, CH0 + O_CNT, v);  chk("R2 stopped channel holds", v, 0);
   endtask

   task automatic t_mask();
      logic [31:0] v;
      wr(0, CH0 + O_MASK, 32'hFF);
      rd(0, CH0 + O_MASK, v); chk("R9 mask set", v, 32'hFF);
      wr(0, CH0 + O_MASK, 32'h00);
      rd(0, CH0 + O_MASK, v); chk("R9 zeros do not clear", v, 32'hFF);
      rd(0, CH1 + O_MASK, v); chk("R9 other channel untouched", v, 0);
   endtask

   task automatic t_divide();
      logic [31:0] v;
      wr(1, CH0 + O_MODE, 32'h2);
      wr(1, CH0 + O_CMD, 32'h1);
      wr(1, CH1 + O_MODE, 32'h1);
      wr(1, CH1 + O_CMD, 32'h1);
      sync_one(1);
      idle(20);
      rd(1, CH0 + O_CNT, v); chk("R3 div8 k=20", v, 2);
      rd(1, CH1 + O_CNT, v); chk("R3 div2 k=20", v, 10);
      idle(20);
      rd(1, CH0 + O_CNT, v); chk("R3 div8 k=40", v, 5);
      rd(1, CH1 + O_CNT, v); chk("R3 div2 k=40", v, 20);
      wr(1, CH0 + O_MODE, 32'h3);
      sync_one(1);
      idle(70);
      rd(1, CH0 + O_CNT, v); chk("R3 div32 k=70", v, 2);
   endtask

   task automatic t_sync_readonly();
      logic [31:0] v;
      wr(1, CH0 + O_MODE, 32'h0);
      wr(1, CH1 + O_MODE, 32'h0);
      sync_one(1);
      idle(7);
      rd(1, CH0 + O_CNT, v); chk("R7 ch0 restarted", v, 7);
      rd(1, CH1 + O_CNT, v); chk("R7 ch1 restarted same edge", v, 7);
      idle(5);
      wr(1, CH0 + O_CNT, 32'h1234);
      rd(1, CH0 + O_CNT, v); chk("R8 count write ignored", v, k);
   endtask

   task automatic t_wave();
      logic [31:0] v;
      wr(0, CH0 + O_MODE, 32'h8);
      wr(0, CH0 + O_CMPA, 32'd5);
      wr(0, CH0 + O_CMPC, 32'd9);
      wr(0, CH0 + O_CMD, 32'h1);
      sync_one(0);
      idle(4); chk("R5 low before A", {31'd0, a_wave[0]}, 0);
      idle(1); chk("R5 set at A", {31'd0, a_wave[0]}, 1);
      idle(3); chk("R5 high until C", {31'd0, a_wave[0]}, 1);
      idle(1); chk("R5 cleared at C", {31'd0, a_wave[0]}, 0);
      wr(0, CH0 + O_CMPA, 32'd12);
      wr(0, CH0 + O_CMPC, 32'd12);
      idle(1);
      rd(0, CH0 + O_CNT, v); chk("R5 count at double match", v, 12);
      chk("R5 C wins on double match", {31'd0, a_wave[0]}, 0);
      wr(0, CH0 + O_CMPA, 32'd20);
      idle(7); chk("R5 set at new A", {31'd0, a_wave[0]}, 1);
      wr(0, CH0 + O_MODE, 32'h0);
      idle(1); chk("R5 low with waveform off", {31'd0, a_wave[0]}, 0);
   endtask

   task automatic t_chain();
      logic [31:0] u1, u2, lo, bv;
      int klow;
      bit expect_split;
      int valid_seen = 0;
      int split_seen = 0;
      wr(0, CH0 + O_CMPA, 32'h0000);
      wr(0, CH0 + O_CMPC, 32'h8000);
      wr(0, CH0 + O_MODE, 32'h8);
      wr(0, CH1 + O_MODE, 32'h4);
      wr(0, CH1 + O_CMD, 32'h1);
      wr(0, BLK + 8'h04, 32'h1);
      sync_both();
      rd(0, CH1 + O_CNT, u1); chk("R6 upper zero after sync", u1, 0);
      idle(65516);
      for (int t = 0; t < 6; t++) begin
         rd(0, CH1 + O_CNT, u1);
         idle(4);
         klow = k;
         rd(0, CH0 + O_CNT, lo);
         rd(1, CH0 + O_CNT, bv);
         chk("R4 16-bit lower wraps", lo, klow & 32'hFFFF);
         chk("R4 32-bit passes 0xFFFF", bv, klow);
         chk("R6 cascade square wave", {31'd0, a_wave[0]}, (klow >= 65536) ? 1 : 0);
         idle(4);
         rd(0, CH1 + O_CNT, u2);
         idle(1);
         // channel 1 steps at edge 65536+3
         expect_split = (klow - 4 < 65539) && (klow + 4 >= 65539);
         chk("R6 upper step timing", {31'd0, u1 != u2}, {31'd0, expect_split});
         if (u1 == u2) begin
            valid_seen++;
            chk("R10 combined value", {u1[15:0], lo[15:0]}, klow);
         end else begin
            split_seen++;
         end
      end
      chk("R10 carry detected by reread", split_seen, 1);
      chk("R10 valid reads", valid_seen, 5);
      rd(0, CH1 + O_CNT, u1); chk("R6 one step per wrap", u1, 1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0;
      a_addr = '0; b_addr = '0; a_wr = 1'b0; b_wr = 1'b0; a_wd = '0; b_wd = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_mask();
      t_divide();
      t_sync_readonly();
      t_wave();
      t_chain();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule